// File: doc/BRIEF.md
# Glitchless Dual-Frequency Clock Selector

Each clock output of this block carries one of two candidate clocks: a first frequency and a second frequency, both produced by dividers outside the block. Two shared frequency-select pins decide the choice. A small configuration register holds two things for every steerable output: a routing code that ties the output to one pin or to none, and an enable for pin control. This lets one pin steer any subset of the outputs, and lets the two pins work independently of each other.

A change of selection never cuts a clock phase short. The clock being dropped is gated off on its own falling edge, so the cycle in progress finishes. The clock being taken up is gated on only after the other gate has been seen closed, and its first pulse starts on its own rising edge. The last outputs have no second frequency and always carry their first clock. A reduced build with fewer outputs comes from the parameters.

Top module: `dfs_clock_selector`

## Requirements
- R1: A cycle of `clk` with `cfg_we` high loads the routing codes and the pin-control enables. Reset clears both, so every routing code becomes 2'b00 and every enable becomes 0.
- R2: A steerable output `i` (i < NUM_SEL_OUT) carries `f2_clk[i]` when both of these hold: its enable bit `cfg_en_in[i]` is set, and either its routing code (bits 2i+1:2i) is 2'b01 with `fsel[0]` high or the code is 2'b10 with `fsel[1]` high. In every other case it carries `f1_clk[i]`. Codes 2'b00 and 2'b11 link the output to no pin.
- R3: An output with index NUM_SEL_OUT or above always carries `f1_clk` of the same index, whatever the pins and the configuration hold.
- R4: One pin can steer several outputs at the same time, and each pin acts only on the outputs routed to it.
- R5: For any output, the gates of its two candidate clocks are never open together. A gate opens only after the other gate has been closed for at least one sample of `clk`.
- R6: No high or low phase on any output is shorter than half a period of its faster candidate clock. Every switch lets the old cycle complete and begins the new clock at its rising edge.
- R7: While `rst_n` is low, every output is low. After reset, every output carries its first frequency, and its first pulse is a full one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_map_in | input | 2*NUM_SEL_OUT | Routing codes, two bits per steerable output |
| cfg_en_in | input | NUM_SEL_OUT | Pin-control enables, one per steerable output |
| fsel | input | 2 | Asynchronous frequency-select pins |
| f1_clk | input | NUM_OUT | First-frequency candidate clock of each output |
| f2_clk | input | NUM_SEL_OUT | Second-frequency candidate clock of each steerable output |
| clk_out | output | NUM_OUT | Selected output clocks |

## Verification
The bench builds the default configuration: eight outputs, six of them steerable, and both pins. This puts the steerable mux cell and the fixed cell under test in the same run. All four routing codes can appear on every steerable output. Every candidate clock has its own period, none in phase with another, so each measured output period shows which clock was chosen. A phase monitor runs on every output and catches any runt that a switch could produce, for every pairing of pin and output that the random configurations reach.

// File: rtl/dfs_pkg.sv
`timescale 1ns/1ps
// Shared constants and the routing-code type for the clock selector.
// Assumes exactly two select pins, so a routing code is two bits wide.
package dfs_pkg;
    localparam int N_PINS = 2;
    localparam int MAP_W  = 2;

    typedef enum logic [MAP_W-1:0] {
        ROUTE_NONE = 2'b00,
        ROUTE_PIN0 = 2'b01,
        ROUTE_PIN1 = 2'b10,
        ROUTE_RSVD = 2'b11
    } route_e;
endpackage

// File: rtl/dfs_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser that brings a single bit into the domain of clk.
// Assumes the input is level-like and stays stable for longer than two cycles of clk.
module dfs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Pass the bit through two flops; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dfs_cfg_reg.sv
`timescale 1ns/1ps
// Configuration register that holds the routing codes and the pin-control enables.
// Assumes software changes the register only while the affected outputs may switch freely.
module dfs_cfg_reg #(
    parameter int NUM_SEL_OUT = 6,
    parameter int MAP_W       = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [MAP_W*NUM_SEL_OUT-1:0] map_in,
    input  logic [NUM_SEL_OUT-1:0]       en_in,
    output logic [MAP_W*NUM_SEL_OUT-1:0] map_q,
    output logic [NUM_SEL_OUT-1:0]       en_q
);
    // Load both fields on a write; reset routes nothing and disables pin control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
            en_q  <= '0;
        end else if (we) begin
            map_q <= map_in;
            en_q  <= en_in;
        end
    end
endmodule

// File: rtl/dfs_glitchless_mux.sv
`timescale 1ns/1ps
// Break-before-make mux between two unrelated clocks.
// Each gate changes only on the falling edge of its own clock, and opens only after
// the peer gate has been seen closed through a synchroniser in its own domain.
// Assumes rst_n is held low for several cycles of both clocks.
module dfs_glitchless_mux (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic pick_b,
    output logic clk_o,
    output logic on_a,
    output logic on_b
);
    logic pick_in_a, pick_in_b, peer_b_in_a, peer_a_in_b;

    dfs_sync2 u_pick_a (.clk(clk_a), .rst_n(rst_n), .d(pick_b), .q(pick_in_a));
    dfs_sync2 u_peer_a (.clk(clk_a), .rst_n(rst_n), .d(on_b),   .q(peer_b_in_a));
    dfs_sync2 u_pick_b (.clk(clk_b), .rst_n(rst_n), .d(pick_b), .q(pick_in_b));
    dfs_sync2 u_peer_b (.clk(clk_b), .rst_n(rst_n), .d(on_a),   .q(peer_a_in_b));

    // Gate A: open when A is wanted and B is seen closed; switch only while clk_a is low.
    always_ff @(negedge clk_a) begin
        if (!rst_n) on_a <= 1'b0;
        else        on_a <= !pick_in_a && !peer_b_in_a;
    end

    // Gate B: open when B is wanted and A is seen closed; switch only while clk_b is low.
    always_ff @(negedge clk_b) begin
        if (!rst_n) on_b <= 1'b0;
        else        on_b <= pick_in_b && !peer_a_in_b;
    end

    assign clk_o = (clk_a && on_a) || (clk_b && on_b);
endmodule

// File: rtl/dfs_clock_selector.sv
`timescale 1ns/1ps
// Dual-frequency clock selector for a bank of outputs.
// The first NUM_SEL_OUT outputs can be steered by the select pins through the
// configuration register; the rest always carry their first clock.
// Assumes the select pins are asynchronous and the configuration is quasi-static.
module dfs_clock_selector #(
    parameter int NUM_OUT     = 8,
    parameter int NUM_SEL_OUT = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_we,
    input  logic [dfs_pkg::MAP_W*NUM_SEL_OUT-1:0] cfg_map_in,
    input  logic [NUM_SEL_OUT-1:0]                cfg_en_in,
    input  logic [dfs_pkg::N_PINS-1:0]            fsel,
    input  logic [NUM_OUT-1:0]                    f1_clk,
    input  logic [NUM_SEL_OUT-1:0]                f2_clk,
    output logic [NUM_OUT-1:0]                    clk_out
);
    import dfs_pkg::*;

    localparam int MAP_BITS = MAP_W * NUM_SEL_OUT;

    logic [MAP_BITS-1:0]    map_q;
    logic [NUM_SEL_OUT-1:0] ena_q;
    logic [NUM_SEL_OUT-1:0] pick_b;
    logic [NUM_OUT-1:0]     on_a;
    logic [NUM_OUT-1:0]     on_b;

    dfs_cfg_reg #(.NUM_SEL_OUT(NUM_SEL_OUT), .MAP_W(MAP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .map_in(cfg_map_in), .en_in(cfg_en_in),
        .map_q(map_q), .en_q(ena_q)
    );

    // Decode each routing code into the selected pin level, gated by the output's enable.
    always_comb begin
        for (int i = 0; i < NUM_SEL_OUT; i++) begin
            case (route_e'(map_q[i*MAP_W +: MAP_W]))
                ROUTE_PIN0: pick_b[i] = ena_q[i] && fsel[0];
                ROUTE_PIN1: pick_b[i] = ena_q[i] && fsel[1];
                default:    pick_b[i] = 1'b0;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        if (g < NUM_SEL_OUT) begin : g_steer
            dfs_glitchless_mux u_mux (
                .clk_a(f1_clk[g]), .clk_b(f2_clk[g]), .rst_n(rst_n),
                .pick_b(pick_b[g]), .clk_o(clk_out[g]),
                .on_a(on_a[g]), .on_b(on_b[g])
            );
        end else begin : g_fixed
            dfs_glitchless_mux u_mux (
                .clk_a(f1_clk[g]), .clk_b(f1_clk[g]), .rst_n(rst_n),
                .pick_b(1'b0), .clk_o(clk_out[g]),
                .on_a(on_a[g]), .on_b(on_b[g])
            );
        end
    end
endmodule

// File: rtl/dfs_clock_selector_chk.sv
`timescale 1ns/1ps
// Checker for the clock selector: configuration loading, exclusive gates and the
// fixed outputs. Sampled on the configuration clock, which runs faster than every candidate.
module dfs_clock_selector_chk #(
    parameter int NUM_OUT     = 8,
    parameter int NUM_SEL_OUT = 6,
    parameter int MAP_BITS    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic [MAP_BITS-1:0]    cfg_map_in,
    input logic [NUM_SEL_OUT-1:0] cfg_en_in,
    input logic [MAP_BITS-1:0]    map_q,
    input logic [NUM_SEL_OUT-1:0] ena_q,
    input logic [NUM_OUT-1:0]     on_a,
    input logic [NUM_OUT-1:0]     on_b
);
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (map_q == $past(cfg_map_in) && ena_q == $past(cfg_en_in))); // R1

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_each
        AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(on_a[i] && on_b[i])); // R5
        AST_OPEN_A_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(on_a[i]) |-> !$past(on_b[i])); // R5
        AST_OPEN_B_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(on_b[i]) |-> !$past(on_a[i])); // R5
    end

    for (genvar k = NUM_SEL_OUT; k < NUM_OUT; k++) begin : g_fixed
        AST_FIXED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            !on_b[k]); // R3
    end
endmodule

bind dfs_clock_selector dfs_clock_selector_chk #(
    .NUM_OUT(NUM_OUT), .NUM_SEL_OUT(NUM_SEL_OUT), .MAP_BITS(MAP_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_map_in(cfg_map_in),
    .cfg_en_in(cfg_en_in), .map_q(map_q), .ena_q(ena_q), .on_a(on_a), .on_b(on_b)
);

// File: tb/tb_dfs_clock_selector.sv
`timescale 1ns/1ps
module tb_dfs_clock_selector;
    localparam int NO = 8;
    localparam int NS = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [2*NS-1:0] cfg_map_in = '0;
    logic [NS-1:0]   cfg_en_in = '0;
    logic [1:0]      fsel = 2'b00;
    logic [NO-1:0]   f1_clk = '0;
    logic [NS-1:0]   f2_clk = '0;
    wire  [NO-1:0]   clk_out;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;
    bit done   = 1'b0;

    logic [2*NS-1:0] sh_map = '0;
    logic [NS-1:0]   sh_en  = '0;

    real last_rise [NO];
    real period    [NO];
    real last_edge [NO];
    int  runts     [NO];

    dfs_clock_selector #(.NUM_OUT(NO), .NUM_SEL_OUT(NS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_map_in(cfg_map_in),
        .cfg_en_in(cfg_en_in), .fsel(fsel), .f1_clk(f1_clk), .f2_clk(f2_clk),
        .clk_out(clk_out)
    );

    // 125 MHz configuration clock.
    always #4 clk = ~clk;

    // Half periods of the candidates; the first one is always the faster of a pair.
    function automatic real h1(input int i);
        return 9.7 + 2.3 * i;
    endfunction
    function automatic real h2(input int i);
        return 14.1 + 3.1 * i;
    endfunction

    for (genvar g = 0; g < NO; g++) begin : g_c1
        always #(h1(g)) f1_clk[g] = ~f1_clk[g];
    end
    for (genvar g = 0; g < NS; g++) begin : g_c2
        always #(h2(g)) f2_clk[g] = ~f2_clk[g];
    end

    // Measure the periods and watch every phase for runts.
    for (genvar g = 0; g < NO; g++) begin : g_mon
        initial begin
            last_rise[g] = 0.0; period[g] = 0.0; last_edge[g] = 0.0; runts[g] = 0;
        end
        always @(posedge clk_out[g]) begin
            period[g]    = $realtime - last_rise[g];
            last_rise[g] = $realtime;
        end
        always @(clk_out[g]) begin
            if (armed && ($realtime - last_edge[g]) < h1(g) - 0.05) runts[g]++;
            last_edge[g] = $realtime;
        end
    end

    // Reference model: is the second frequency expected on output i.
    function automatic bit exp_f2(input int i);
        logic [1:0] code;
        if (i >= NS) return 1'b0;
        if (!sh_en[i]) return 1'b0;
        code = sh_map[2*i +: 2];
        if (code == 2'b01) return fsel[0];
        if (code == 2'b10) return fsel[1];
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, expv);
        end
    endtask

    task automatic write_cfg(input logic [2*NS-1:0] m, input logic [NS-1:0] e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_map_in = m; cfg_en_in = e;
        @(negedge clk);
        cfg_we = 1'b0;
        sh_map = m; sh_en = e;
    endtask

    // Let every switch settle, then compare each output period with the model.
    task automatic check_all(input string req);
        real expv, d;
        #1200;
        @(negedge clk);
        for (int i = 0; i < NO; i++) begin
            expv = exp_f2(i) ? 2.0 * h2(i) : 2.0 * h1(i);
            d = period[i] - expv;
            if (d < 0.0) d = -d;
            check(d < 0.05 && ($realtime - last_rise[i]) < expv + 1.0,
                  (i >= NS) ? {req, " R3"} : req,
                  $sformatf("period of output %0d", i), period[i], expv);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (30) @(negedge clk);
        // R7: low while held in reset
        for (int k = 0; k < 3; k++) begin
            check(clk_out == '0, "R7", "outputs during reset", real'(clk_out), 0.0);
            repeat (3) @(negedge clk);
        end
        armed = 1'b1;
        rst_n = 1'b1;
        check_all("R7 R1");

        // R4 R1: both pins, several outputs each
        write_cfg({2'b10, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01}, 6'b111111);
        fsel = 2'b01;
        check_all("R4");
        fsel = 2'b10;
        check_all("R4");
        fsel = 2'b11;
        check_all("R4");
        // R2: reserved code and no-pin code ignore the pins
        write_cfg({2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00}, 6'b111111);
        check_all("R2");
        // R2: disabled outputs ignore a routed pin
        write_cfg({2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10}, 6'b000000);
        check_all("R2");
        // R2: back to F1 from F2 with a pin drop
        write_cfg({2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10}, 6'b111111);
        check_all("R2");
        fsel = 2'b00;
        check_all("R2");

        // R2: random configurations and pin levels
        for (int it = 0; it < 24; it++) begin
            logic [2*NS-1:0] m;
            logic [NS-1:0]   e;
            m = 12'($urandom);
            e = 6'($urandom);
            write_cfg(m, e);
            fsel = 2'($urandom);
            check_all("R2");
            if (it % 3 == 0) begin
                fsel = ~fsel;
                check_all("R2");
            end
        end

        // R5 R6: no runt phase on any output over the whole run
        for (int i = 0; i < NO; i++)
            check(runts[i] == 0, "R5 R6", $sformatf("runt phases on output %0d", i),
                  real'(runts[i]), 0.0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule